// File: doc/BRIEF.md
# Shared Branch Tag Allocator with Per-Thread Masks

This block hands out branch tags to a rename stage that serves several hardware threads at once. All threads share one pool of tags, so the total number of unresolved branches in the core is bounded by the pool size and not by the thread count. The block keeps one mask per thread, with one bit per tag. A set bit means that the thread owns that tag and that the branch holding it is still unresolved. No tag can be owned by two threads at the same time, and a tag is free exactly when no mask holds it.

Each cycle the block takes one allocation request and one resolution. An allocation request carries a thread number. A resolution carries a one-hot tag and a mispredict flag. The resolve port is decoded into one of four actions:
- `RES_IDLE`: nothing to do.
- `RES_RETIRE`: the branch was predicted correctly. Its tag is freed and broadcast so that waiting instructions can drop their dependence on it.
- `RES_SQUASH`: the branch was mispredicted. The block reports the owning thread and the set of that thread's tags to kill, then frees them.
- `RES_STRAY`: the tag is not outstanding, and the resolution is ignored.

The resolution acts before the allocation in the same cycle. An age matrix records, for each tag, which tags were already outstanding when it was allocated. A squash therefore removes only the tags of its own thread that are younger than the mispredicted branch.

Top module: `brtag_pool`

## Requirements
- R1: After reset every mask is zero, `stall` is low, and `alloc_grant`, `clr_valid` and `sq_valid` are low while no request is presented.
- R2: A tag bit is set in at most one thread's mask at any time.
- R3: A request from a thread below NUM_THREADS is granted in the same cycle if any tag is free after resolution. `alloc_tag` is then the one-hot lowest-numbered free tag (bit i means tag i), and that bit is set in the requesting thread's mask from the next cycle on. Without a grant, `alloc_tag` is zero.
- R4: `stall` is high exactly when no tag is free after the current resolution. While it is high, no request is granted and the masks keep their value.
- R5: A correct resolution of an outstanding tag raises `clr_valid` in the same cycle with `clr_tag` equal to the tag, and clears that single bit from its owner's mask at the next edge.
- R6: A misprediction of an outstanding tag raises `sq_valid` in the same cycle. `sq_tid` is the owning thread, `sq_tag` is the tag, and `sq_mask` holds the tag plus every tag of the same thread that was allocated after it. All `sq_mask` bits are cleared at the next edge.
- R7: A misprediction leaves every bit of every other thread untouched, including bits allocated after the mispredicted branch.
- R8: A tag freed by a resolution can be granted in the same cycle, even when the pool was full before that resolution.
- R9: A resolution whose tag is not outstanding raises no output and changes no mask.
- R10: `mask_flat[t*NUM_TAGS +: NUM_TAGS]` shows thread t's mask as registered state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_req | input | 1 | Request a tag for a newly renamed branch |
| alloc_tid | input | TW | Thread making the request |
| alloc_grant | output | 1 | Request granted this cycle |
| alloc_tag | output | NUM_TAGS | One-hot granted tag, zero without a grant |
| stall | output | 1 | No tag free after this cycle's resolution |
| res_valid | input | 1 | A branch resolves this cycle |
| res_mispredict | input | 1 | The resolving branch was mispredicted |
| res_tag | input | NUM_TAGS | One-hot tag of the resolving branch |
| clr_valid | output | 1 | Correct resolution broadcast |
| clr_tag | output | NUM_TAGS | Tag being released by a correct resolution |
| sq_valid | output | 1 | Misprediction squash request |
| sq_tid | output | TW | Thread to squash |
| sq_tag | output | NUM_TAGS | Mispredicted tag |
| sq_mask | output | NUM_TAGS | Tags killed by the squash |
| mask_flat | output | NUM_THREADS*NUM_TAGS | All per-thread masks, thread 0 in the low bits |

## Verification
The bench fills the pool from a mix of threads and requests one more tag. A design that ignored the full condition would grant a tag that is already taken, and two masks would then share a bit. It resolves a tag while the pool is full and requests in the same cycle. A design that applied allocation first would stall instead of reusing the freed tag. It squashes a branch in the middle of an interleaved sequence, which catches an age matrix that kills older tags or touches other threads. It also reuses tags after they are freed, which catches stale age entries that would widen a later squash. Finally it resolves tags that are not outstanding, which must have no effect at all.

// File: rtl/brtag_pkg.sv
package brtag_pkg;
    // Decoded action of the resolve port in one cycle.
    typedef enum logic [1:0] {
        RES_IDLE   = 2'd0,
        RES_RETIRE = 2'd1,
        RES_SQUASH = 2'd2,
        RES_STRAY  = 2'd3
    } res_kind_e;
endpackage

// File: rtl/brtag_pick.sv
// Lowest-index one-hot picker over a free vector.
module brtag_pick #(
    parameter int W = 8
) (
    input  logic [W-1:0] free_vec,
    output logic [W-1:0] pick_oh,
    output logic         pick_any
);
    logic [W:0] seen;
    assign seen[0] = 1'b0;

    for (genvar i = 0; i < W; i++) begin : g_chain
        assign seen[i+1]  = seen[i] | free_vec[i];
        assign pick_oh[i] = free_vec[i] & ~seen[i];
    end

    assign pick_any = seen[W];
endmodule

// File: rtl/brtag_age.sv
// Age matrix: row i lists the tags outstanding when tag i was allocated.
module brtag_age #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         alloc_en,
    input  logic [W-1:0] alloc_oh,
    input  logic [W-1:0] older_set,
    input  logic [W-1:0] probe_oh,
    output logic [W-1:0] younger
);
    logic [W-1:0] older_q [W];

    for (genvar i = 0; i < W; i++) begin : g_row
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                older_q[i] <= '0;
            end else if (alloc_en) begin
                if (alloc_oh[i]) begin
                    older_q[i] <= older_set;
                end else begin
                    older_q[i] <= older_q[i] & ~alloc_oh;
                end
            end
        end

        assign younger[i] = |(older_q[i] & probe_oh);

        // R6: a fresh tag never lists itself as older than itself
        a_r6_no_self_age: assert property (@(posedge clk) disable iff (!rst_n)
            (alloc_en && alloc_oh[i]) |=> !older_q[i][i]);
    end
endmodule

// File: rtl/brtag_pool.sv
module brtag_pool #(
    parameter int NUM_THREADS = 4,
    parameter int NUM_TAGS    = 8,
    localparam int TW = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            alloc_req,
    input  logic [TW-1:0]                   alloc_tid,
    output logic                            alloc_grant,
    output logic [NUM_TAGS-1:0]             alloc_tag,
    output logic                            stall,
    input  logic                            res_valid,
    input  logic                            res_mispredict,
    input  logic [NUM_TAGS-1:0]             res_tag,
    output logic                            clr_valid,
    output logic [NUM_TAGS-1:0]             clr_tag,
    output logic                            sq_valid,
    output logic [TW-1:0]                   sq_tid,
    output logic [NUM_TAGS-1:0]             sq_tag,
    output logic [NUM_TAGS-1:0]             sq_mask,
    output logic [NUM_THREADS*NUM_TAGS-1:0] mask_flat
);
    import brtag_pkg::*;

    logic [NUM_TAGS-1:0]    mask_q   [NUM_THREADS];
    logic [NUM_TAGS-1:0]    mask_mid [NUM_THREADS];
    logic [NUM_THREADS-1:0] hit;
    logic [TW-1:0]          owner;
    logic [NUM_TAGS-1:0]    busy_q, busy_mid, younger, clear_vec, pick_oh;
    logic                   pick_any, tid_ok;
    res_kind_e              res_kind;

    // Which thread owns the resolving tag
    always_comb begin
        owner  = '0;
        busy_q = '0;
        for (int t = 0; t < NUM_THREADS; t++) begin
            hit[t] = |(mask_q[t] & res_tag);
            if (hit[t]) owner = TW'(t);
            busy_q = busy_q | mask_q[t];
        end
    end

    always_comb begin
        if (!res_valid)          res_kind = RES_IDLE;
        else if (!(|hit))        res_kind = RES_STRAY;
        else if (res_mispredict) res_kind = RES_SQUASH;
        else                     res_kind = RES_RETIRE;
    end

    brtag_age #(.W(NUM_TAGS)) i_age (
        .clk       (clk),
        .rst_n     (rst_n),
        .alloc_en  (alloc_grant),
        .alloc_oh  (pick_oh),
        .older_set (busy_mid),
        .probe_oh  (res_tag),
        .younger   (younger)
    );

    // Resolution outputs
    always_comb begin
        clear_vec = '0;
        clr_valid = 1'b0;
        sq_valid  = 1'b0;
        unique case (res_kind)
            RES_IDLE, RES_STRAY: ;
            RES_RETIRE: begin
                clr_valid = 1'b1;
                clear_vec = res_tag;
            end
            RES_SQUASH: begin
                sq_valid  = 1'b1;
                clear_vec = (younger | res_tag) & mask_q[owner];
            end
        endcase
    end

    assign clr_tag = clr_valid ? res_tag : '0;
    assign sq_tag  = sq_valid ? res_tag : '0;
    assign sq_tid  = sq_valid ? owner : '0;
    assign sq_mask = sq_valid ? clear_vec : '0;

    // Resolution is applied before allocation
    always_comb begin
        busy_mid = '0;
        for (int t = 0; t < NUM_THREADS; t++) begin
            mask_mid[t] = mask_q[t] & ~clear_vec;
            busy_mid    = busy_mid | mask_mid[t];
        end
    end

    brtag_pick #(.W(NUM_TAGS)) i_pick (
        .free_vec (~busy_mid),
        .pick_oh  (pick_oh),
        .pick_any (pick_any)
    );

    assign tid_ok      = int'(alloc_tid) < NUM_THREADS;
    assign stall       = !pick_any;
    assign alloc_grant = alloc_req && tid_ok && pick_any;
    assign alloc_tag   = alloc_grant ? pick_oh : '0;

    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mask_q[t] <= '0;
            end else if (alloc_grant && alloc_tid == TW'(t)) begin
                mask_q[t] <= mask_mid[t] | pick_oh;
            end else begin
                mask_q[t] <= mask_mid[t];
            end
        end
        assign mask_flat[t*NUM_TAGS +: NUM_TAGS] = mask_q[t];
    end

    for (genvar b = 0; b < NUM_TAGS; b++) begin : g_col
        logic [NUM_THREADS-1:0] col;
        for (genvar t = 0; t < NUM_THREADS; t++) begin : g_bit
            assign col[t] = mask_q[t][b];
        end
        a_r2_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(col));
    end

    a_r3_grant_free: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_grant |-> ($onehot(alloc_tag) && ((alloc_tag & busy_q & ~clear_vec) == '0)));

    a_r3_grant_sets: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_grant |=> ((busy_q & $past(alloc_tag)) != '0));

    a_r5_retire_frees: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_valid && !alloc_grant) |=> ((busy_q & $past(clr_tag)) == '0));

    a_r6_squash_frees: assert property (@(posedge clk) disable iff (!rst_n)
        (sq_valid && !alloc_grant) |=> ((busy_q & $past(sq_mask)) == '0));

    a_r4_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && !res_valid) |=> $stable(busy_q));
endmodule

// File: tb/test_brtag_pool.sv
module test_brtag_pool;
    localparam int T  = 4;
    localparam int B  = 8;
    localparam int TW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic alloc_req = 1'b0;
    logic [TW-1:0] alloc_tid = '0;
    logic res_valid = 1'b0, res_mispredict = 1'b0;
    logic [B-1:0] res_tag = '0;
    logic alloc_grant, stall, clr_valid, sq_valid;
    logic [B-1:0] alloc_tag, clr_tag, sq_tag, sq_mask;
    logic [TW-1:0] sq_tid;
    logic [T*B-1:0] mask_flat;

    always #10 clk = ~clk;

    brtag_pool #(.NUM_THREADS(T), .NUM_TAGS(B)) i_brtag_pool (
        .clk(clk), .rst_n(rst_n),
        .alloc_req(alloc_req), .alloc_tid(alloc_tid),
        .alloc_grant(alloc_grant), .alloc_tag(alloc_tag), .stall(stall),
        .res_valid(res_valid), .res_mispredict(res_mispredict), .res_tag(res_tag),
        .clr_valid(clr_valid), .clr_tag(clr_tag),
        .sq_valid(sq_valid), .sq_tid(sq_tid), .sq_tag(sq_tag), .sq_mask(sq_mask),
        .mask_flat(mask_flat)
    );

    int vectors = 0;
    int errors  = 0;
    logic [B-1:0] mdl [T];
    int seq [B];
    int seq_ctr = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic check_masks(input string req);
        for (int t = 0; t < T; t++)
            check(mask_flat[t*B +: B] == mdl[t], req, $sformatf("mask of thread %0d", t),
                  32'(mask_flat[t*B +: B]), 32'(mdl[t]));
    endtask

    // One cycle: check state, drive, check combinational outputs, advance model
    task automatic step(input bit rq, input int tid, input bit rv, input bit mis,
                        input logic [B-1:0] tag, input string req);
        logic [B-1:0] clear, busy, exp_tag, younger_set;
        bit known, exp_grant;
        int own, midx, low;
        @(negedge clk);
        check_masks("R10");
        alloc_req = rq; alloc_tid = TW'(tid);
        res_valid = rv; res_mispredict = mis; res_tag = tag;
        #2;
        known = 1'b0; own = 0; midx = 0;
        for (int t = 0; t < T; t++) if ((mdl[t] & tag) != '0) begin known = 1'b1; own = t; end
        for (int i = 0; i < B; i++) if (tag[i]) midx = i;
        clear = '0;
        if (rv && known) begin
            if (mis) begin
                younger_set = '0;
                for (int i = 0; i < B; i++)
                    if (mdl[own][i] && seq[i] >= seq[midx]) younger_set[i] = 1'b1;
                clear = younger_set;
            end else begin
                clear = tag;
            end
        end
        busy = '0;
        for (int t = 0; t < T; t++) busy = busy | (mdl[t] & ~clear);
        low = -1;
        for (int i = B - 1; i >= 0; i--) if (!busy[i]) low = i;
        exp_grant = rq && (low >= 0);
        exp_tag = exp_grant ? B'(1) << low : '0;
        check(stall == (low < 0), "R4", "stall", 32'(stall), 32'(low < 0));
        check(alloc_grant == exp_grant, req, "alloc_grant", 32'(alloc_grant), 32'(exp_grant));
        check(alloc_tag == exp_tag, "R3", "alloc_tag", 32'(alloc_tag), 32'(exp_tag));
        check(clr_valid == (rv && known && !mis), "R5", "clr_valid", 32'(clr_valid), 32'(rv && known && !mis));
        if (rv && known && !mis) check(clr_tag == tag, "R5", "clr_tag", 32'(clr_tag), 32'(tag));
        check(sq_valid == (rv && known && mis), rv && !known ? "R9" : "R6", "sq_valid",
              32'(sq_valid), 32'(rv && known && mis));
        if (rv && known && mis) begin
            check(sq_tid == TW'(own), "R6", "sq_tid", 32'(sq_tid), 32'(own));
            check(sq_tag == tag, "R6", "sq_tag", 32'(sq_tag), 32'(tag));
            check(sq_mask == clear, "R7", "sq_mask", 32'(sq_mask), 32'(clear));
        end
        for (int t = 0; t < T; t++) mdl[t] = mdl[t] & ~clear;
        if (exp_grant) begin
            mdl[tid] = mdl[tid] | exp_tag;
            seq[low] = seq_ctr;
            seq_ctr++;
        end
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h1d2c));
        for (int t = 0; t < T; t++) mdl[t] = '0;
        for (int i = 0; i < B; i++) seq[i] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R1: reset state
        #2;
        check(mask_flat == '0, "R1", "masks", mask_flat, '0);
        check(!stall && !alloc_grant && !clr_valid && !sq_valid, "R1", "idle outputs",
              {stall, alloc_grant, clr_valid, sq_valid}, '0);
        // R3: interleaved fill, threads 0,1,0,2,1,3,0,2
        step(1, 0, 0, 0, '0, "R3"); step(1, 1, 0, 0, '0, "R3");
        step(1, 0, 0, 0, '0, "R3"); step(1, 2, 0, 0, '0, "R3");
        step(1, 1, 0, 0, '0, "R3"); step(1, 3, 0, 0, '0, "R3");
        step(1, 0, 0, 0, '0, "R3"); step(1, 2, 0, 0, '0, "R3");
        // R4: pool full, extra request refused
        step(1, 1, 0, 0, '0, "R4");
        step(1, 3, 0, 0, '0, "R4");
        // R8: retire tag 3 while full and request in the same cycle
        step(1, 1, 1, 0, 8'b0000_1000, "R8");
        // R9: stray resolution of a tag no longer held after a retire
        step(0, 0, 1, 0, 8'b0000_0010, "R5");
        step(0, 0, 1, 1, 8'b0000_0010, "R9");
        // R6/R7: squash thread 0 at tag 2, sparing thread 1 and 2 younger tags
        step(0, 0, 1, 1, 8'b0000_0100, "R6");
        step(1, 2, 0, 0, '0, "R3");
        step(1, 0, 1, 1, 8'b0000_0001, "R7");
        // Random mix
        for (int n = 0; n < 4000; n++) begin
            int idx;
            idx = int'($urandom % B);
            step(($urandom % 4) != 0, int'($urandom % T), ($urandom % 2) == 1,
                 ($urandom % 10) < 3, B'(1) << idx, "R3");
        end
        step(0, 0, 0, 0, '0, "R2");
        @(negedge clk);
        check_masks("R10");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule